// File: doc/BRIEF.md
# PWM Interrupt Culling Controller

This block runs beside a triangle-wave PWM timer. It holds a small up/down counter that climbs from zero to a programmable period and falls back to zero. Reaching the top gives a peak event and reaching the bottom gives a valley event. Each event source has its own enable. A shared cull counter suppresses a programmable number of enabled events and then lets the next one through as a one-clock interrupt pulse.

The same block owns a bank of compare registers and the active buffer registers the timer would use. Software writes compare values through a plain write port. In immediate mode a write lands in the active buffer at once. In batch mode the active buffers reload only at a transfer, and a transfer must first be armed by a write to compare slot 1. The transfer point is either every peak and valley event, or only an event that also produces an interrupt. Any nonzero cull count forces the second choice, so buffer reloads are thinned out together with the interrupts.

Top module: `pwm_cull_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `cnt_o` is 0, `cnt_up_o` is 1, both interrupt outputs are 0 and every slice of `active_o` is 0.
- R2: With `period_i` = P ≥ 1, the counter moves by one each clock. It rises while `cnt_up_o` is 1. A sample of P while rising is followed by P-1 with `cnt_up_o` 0. A sample of 0 while falling is followed by 1 with `cnt_up_o` 1. A period of 0 holds the counter at 0 and raises no events.
- R3: `peak_irq_o` is a one-cycle pulse that is only raised in the cycle after a sample of `cnt_o` = P with `cnt_up_o` = 1. `valley_irq_o` is likewise only raised in the cycle after a sample of `cnt_o` = 0 with `cnt_up_o` = 0.
- R4: One shared cull counter is loaded with 0 at reset and is decremented by each enabled event. An enabled event that finds it at 0 emits its interrupt and reloads it with `cull_n_i`. So after reset the first enabled event fires, and then each group of `cull_n_i` events is suppressed before the next one fires. A `cull_n_i` of 0 lets every enabled event fire.
- R5: An event whose source enable (`peak_ie_i`, `valley_ie_i`) is 0 never raises its interrupt and does not advance the cull counter.
- R6: With `imm_mode_i` = 1, a write of D to slot S appears on `active_o[S*DATA_W +: DATA_W]` in the cycle after the write.
- R7: With `imm_mode_i` = 0, `xfer_cull_i` = 0 and `cull_n_i` = 0, writes to any slot other than 1 leave `active_o` unchanged. After a write to slot 1, all slots are copied from the compare registers at the clock edge that ends the next sample showing a peak or valley event, whether or not that source is enabled.
- R8: With `imm_mode_i` = 0 and either `xfer_cull_i` = 1 or `cull_n_i` ≠ 0, an armed transfer happens only at the edge that raises an interrupt. `active_o` therefore changes only together with a rising interrupt output.
- R9: A transfer clears the armed state. Later writes to slots other than 1 stay out of `active_o` until slot 1 is written again.
- R10: A write to slot 1 at the same edge as a transfer lets the transfer copy the old slot-1 value and leaves the transfer armed. The new value then loads at the next transfer point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_i | input | CNT_W | Top value of the triangle count |
| peak_ie_i | input | 1 | Allow peak interrupts |
| valley_ie_i | input | 1 | Allow valley interrupts |
| cull_n_i | input | CULL_W | Number of enabled events suppressed between interrupts |
| xfer_cull_i | input | 1 | In batch mode, transfer only at interrupt events |
| imm_mode_i | input | 1 | 1: writes go straight to active buffers; 0: batch reload |
| wr_en_i | input | 1 | Compare register write strobe |
| wr_sel_i | input | $clog2(NUM_CMP) | Compare slot addressed by the write |
| wr_data_i | input | DATA_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| cnt_up_o | output | 1 | 1 while counting up |
| peak_irq_o | output | 1 | Culled peak interrupt pulse |
| valley_irq_o | output | 1 | Culled valley interrupt pulse |
| active_o | output | NUM_CMP*DATA_W | Active buffer values, slot S at bits S*DATA_W upward |

## Verification
The bench builds the block with CNT_W = 8, DATA_W = 16, NUM_CMP = 4 and CULL_W = 5, and uses periods of 1, 3, 4 and 5. With such short periods a peak or valley arrives every few clocks. The largest cull count of 31 can then be run through two full reload cycles in a few hundred clocks. Period 1 makes peak and valley events arrive on alternate cycles, which is the densest pattern the cull counter can see. Four slots let one test show that writes to slots other than 1 neither arm a transfer nor leak into the active buffers.

// File: rtl/pwm_cull_pkg.sv
// Shared types for the PWM interrupt culling controller.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable types.
package pwm_cull_pkg;

    // Counting direction of the triangle counter.
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    // Events the counter raises in the current cycle.
    typedef struct packed {
        logic peak;
        logic valley;
    } evt_t;

endpackage

// File: rtl/pwm_tri_counter.sv
// Up/down triangle counter: climbs from 0 to period, falls back to 0, repeats.
// Raises a combinational peak or valley event in the cycle the turning value is held.
// Assumes: period may change at any time; a value at or above the period while
// rising is treated as the peak. A period of zero parks the counter at 0.
module pwm_tri_counter
    import pwm_cull_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output evt_t             evt
);

    logic idle;

    // Event decode from the current count and direction.
    always_comb begin
        idle       = (period == '0);
        evt.peak   = !idle && (dir == DIR_UP) && (cnt >= period);
        evt.valley = !idle && (dir == DIR_DOWN) && (cnt == '0);
    end

    // Count and direction update; the direction turns at the peak and at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (idle) begin
            cnt <= '0;
            dir <= DIR_UP;
        end else if (evt.peak) begin
            cnt <= cnt - 1'b1;
            dir <= DIR_DOWN;
        end else if (evt.valley) begin
            cnt <= cnt + 1'b1;
            dir <= DIR_UP;
        end else if (dir == DIR_UP) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_cull_unit.sv
// Interrupt thinning: a shared countdown suppresses enabled events and lets one
// through as a registered one-cycle pulse when it has run down to zero.
// Assumes: peak and valley events never occur in the same cycle.
module pwm_cull_unit
    import pwm_cull_pkg::*;
#(
    parameter int CULL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  evt_t              evt,
    input  logic              peak_ie,
    input  logic              valley_ie,
    input  logic [CULL_W-1:0] cull_n,
    output logic              fire,
    output logic              peak_irq,
    output logic              valley_irq
);

    logic [CULL_W-1:0] left_q;
    logic              peak_hit;
    logic              valley_hit;
    logic              any_hit;

    // Qualify events with their enables and decide whether this one passes.
    always_comb begin
        peak_hit   = evt.peak && peak_ie;
        valley_hit = evt.valley && valley_ie;
        any_hit    = peak_hit || valley_hit;
        fire       = any_hit && (left_q == '0);
    end

    // Countdown of events still to suppress, plus the registered pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q     <= '0;
            peak_irq   <= 1'b0;
            valley_irq <= 1'b0;
        end else begin
            peak_irq   <= peak_hit && fire;
            valley_irq <= valley_hit && fire;
            if (any_hit) begin
                left_q <= fire ? cull_n : left_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_reload_bank.sv
// Compare registers with their active buffers. In immediate mode a write also
// lands in the buffer; in batch mode a write to the arming slot arms a transfer,
// and the next transfer point copies every slot into its buffer.
// Assumes: xfer_point is a single-cycle strobe from the event logic.
module pwm_reload_bank #(
    parameter int NUM_CMP = 4,
    parameter int DATA_W  = 16,
    parameter int ARM_IDX = 1,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SEL_W-1:0]          wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      imm_mode,
    input  logic                      xfer_point,
    output logic [NUM_CMP*DATA_W-1:0] active
);

    logic pend_q;
    logic arm_wr;
    logic do_xfer;

    // Arming write and the actual transfer strobe.
    always_comb begin
        arm_wr  = wr_en && (wr_sel == SEL_W'(ARM_IDX));
        do_xfer = !imm_mode && pend_q && xfer_point;
    end

    // Armed flag: a new arming write wins over the clear done by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (arm_wr) begin
            pend_q <= 1'b1;
        end else if (do_xfer) begin
            pend_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
        logic [DATA_W-1:0] cmp_q;
        logic [DATA_W-1:0] buf_q;
        logic              hit;

        // Write decode for this slot.
        always_comb hit = wr_en && (wr_sel == SEL_W'(i));

        // Compare register written by software.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q <= '0;
            end else if (hit) begin
                cmp_q <= wr_data;
            end
        end

        // Active buffer: direct write in immediate mode, copy on transfer otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                buf_q <= '0;
            end else if (imm_mode) begin
                if (hit) begin
                    buf_q <= wr_data;
                end
            end else if (do_xfer) begin
                buf_q <= cmp_q;
            end
        end

        assign active[i*DATA_W +: DATA_W] = buf_q;
    end

endmodule

// File: rtl/pwm_cull_ctrl.sv
// Top of the PWM interrupt culling controller: triangle counter, interrupt
// culling and compare reload. A nonzero cull count in batch mode forces
// transfers onto interrupt events only.
// Assumes: synchronous active-low reset; NUM_CMP >= 2 so slot 1 exists.
module pwm_cull_ctrl
    import pwm_cull_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_CMP = 4,
    parameter int CULL_W  = 5,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          period_i,
    input  logic                      peak_ie_i,
    input  logic                      valley_ie_i,
    input  logic [CULL_W-1:0]         cull_n_i,
    input  logic                      xfer_cull_i,
    input  logic                      imm_mode_i,
    input  logic                      wr_en_i,
    input  logic [SEL_W-1:0]          wr_sel_i,
    input  logic [DATA_W-1:0]         wr_data_i,
    output logic [CNT_W-1:0]          cnt_o,
    output logic                      cnt_up_o,
    output logic                      peak_irq_o,
    output logic                      valley_irq_o,
    output logic [NUM_CMP*DATA_W-1:0] active_o
);

    dir_e dir;
    evt_t evt;
    logic fire;
    logic cull_xfer;
    logic xfer_point;

    pwm_tri_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (period_i),
        .cnt    (cnt_o),
        .dir    (dir),
        .evt    (evt)
    );

    pwm_cull_unit #(.CULL_W(CULL_W)) u_cull (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .peak_ie    (peak_ie_i),
        .valley_ie  (valley_ie_i),
        .cull_n     (cull_n_i),
        .fire       (fire),
        .peak_irq   (peak_irq_o),
        .valley_irq (valley_irq_o)
    );

    // Transfer point choice: interrupt events only when culling is asked for or forced.
    always_comb begin
        cull_xfer  = xfer_cull_i || (cull_n_i != '0);
        xfer_point = cull_xfer ? fire : (evt.peak || evt.valley);
        cnt_up_o   = (dir == DIR_UP);
    end

    pwm_reload_bank #(
        .NUM_CMP (NUM_CMP),
        .DATA_W  (DATA_W),
        .ARM_IDX (1)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en_i),
        .wr_sel     (wr_sel_i),
        .wr_data    (wr_data_i),
        .imm_mode   (imm_mode_i),
        .xfer_point (xfer_point),
        .active     (active_o)
    );

endmodule

// File: rtl/pwm_cull_chk.sv
// Property checker for pwm_cull_ctrl, attached by bind below.
// Assumes: it sees only the ports of the top module.
module pwm_cull_chk #(
    parameter int CNT_W   = 16,
    parameter int DATA_W  = 16,
    parameter int NUM_CMP = 4,
    parameter int CULL_W  = 5,
    localparam int SEL_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          period_i,
    input logic                      peak_ie_i,
    input logic                      valley_ie_i,
    input logic [CULL_W-1:0]         cull_n_i,
    input logic                      xfer_cull_i,
    input logic                      imm_mode_i,
    input logic                      wr_en_i,
    input logic [SEL_W-1:0]          wr_sel_i,
    input logic [DATA_W-1:0]         wr_data_i,
    input logic [CNT_W-1:0]          cnt_o,
    input logic                      cnt_up_o,
    input logic                      peak_irq_o,
    input logic                      valley_irq_o,
    input logic [NUM_CMP*DATA_W-1:0] active_o
);

    logic              at_peak;
    logic              at_valley;
    logic              imm_wr_q;
    logic [SEL_W-1:0]  imm_sel_q;
    logic [DATA_W-1:0] imm_data_q;
    logic [DATA_W-1:0] imm_slice;

    // Events as seen from the counter ports.
    always_comb begin
        at_peak   = (period_i != '0) && cnt_up_o && (cnt_o >= period_i);
        at_valley = (period_i != '0) && !cnt_up_o && (cnt_o == '0);
        imm_slice = active_o[int'(imm_sel_q)*DATA_W +: DATA_W];
    end

    // Remember the last immediate-mode write for the R6 check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_wr_q   <= 1'b0;
            imm_sel_q  <= '0;
            imm_data_q <= '0;
        end else begin
            imm_wr_q   <= imm_mode_i && wr_en_i;
            imm_sel_q  <= wr_sel_i;
            imm_data_q <= wr_data_i;
        end
    end

    p_dir_turn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        at_peak |=> !cnt_up_o);

    p_peak_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        peak_irq_o |-> $past(at_peak));

    p_valley_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valley_irq_o |-> $past(at_valley));

    p_irq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({peak_irq_o, valley_irq_o}));

    p_peak_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        peak_irq_o |-> $past(peak_ie_i));

    p_valley_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valley_irq_o |-> $past(valley_ie_i));

    p_imm_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        imm_wr_q |-> (imm_slice == imm_data_q));

    p_batch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode_i && !at_peak && !at_valley) |=> $stable(active_o));

    p_xfer_on_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_mode_i && (xfer_cull_i || (cull_n_i != '0)))
            |=> ($stable(active_o) || peak_irq_o || valley_irq_o));

endmodule

bind pwm_cull_ctrl pwm_cull_chk #(
    .CNT_W   (CNT_W),
    .DATA_W  (DATA_W),
    .NUM_CMP (NUM_CMP),
    .CULL_W  (CULL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_i     (period_i),
    .peak_ie_i    (peak_ie_i),
    .valley_ie_i  (valley_ie_i),
    .cull_n_i     (cull_n_i),
    .xfer_cull_i  (xfer_cull_i),
    .imm_mode_i   (imm_mode_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .cnt_o        (cnt_o),
    .cnt_up_o     (cnt_up_o),
    .peak_irq_o   (peak_irq_o),
    .valley_irq_o (valley_irq_o),
    .active_o     (active_o)
);

// File: tb/sim_pwm_cull_ctrl.sv
// Directed bench for pwm_cull_ctrl: one task per scenario, each checking its results.
module sim_pwm_cull_ctrl;

    localparam int CNT_W   = 8;
    localparam int DATA_W  = 16;
    localparam int NUM_CMP = 4;
    localparam int CULL_W  = 5;
    localparam int SEL_W   = 2;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic [CNT_W-1:0]          period_i = 8'd4;
    logic                      peak_ie_i = 1'b0;
    logic                      valley_ie_i = 1'b0;
    logic [CULL_W-1:0]         cull_n_i = '0;
    logic                      xfer_cull_i = 1'b0;
    logic                      imm_mode_i = 1'b0;
    logic                      wr_en_i = 1'b0;
    logic [SEL_W-1:0]          wr_sel_i = '0;
    logic [DATA_W-1:0]         wr_data_i = '0;
    logic [CNT_W-1:0]          cnt_o;
    logic                      cnt_up_o;
    logic                      peak_irq_o;
    logic                      valley_irq_o;
    logic [NUM_CMP*DATA_W-1:0] active_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pwm_cull_ctrl #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_CMP(NUM_CMP), .CULL_W(CULL_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .period_i(period_i), .peak_ie_i(peak_ie_i),
        .valley_ie_i(valley_ie_i), .cull_n_i(cull_n_i), .xfer_cull_i(xfer_cull_i),
        .imm_mode_i(imm_mode_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .cnt_o(cnt_o), .cnt_up_o(cnt_up_o),
        .peak_irq_o(peak_irq_o), .valley_irq_o(valley_irq_o), .active_o(active_o)
    );

    function automatic logic [DATA_W-1:0] slot(int i);
        return active_o[i*DATA_W +: DATA_W];
    endfunction

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Hold reset for two cycles, release at a falling edge.
    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        wr_en_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One-cycle write; returns at the falling edge after the capturing edge.
    task automatic do_write(int sel, logic [DATA_W-1:0] d);
        wr_en_i   = 1'b1;
        wr_sel_i  = SEL_W'(sel);
        wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // R1: reset state.
    task automatic t_reset();
        period_i = 8'd4;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_eq("R1", "cnt in reset", cnt_o, 0);
        check_eq("R1", "dir in reset", cnt_up_o, 1);
        check_eq("R1", "irqs in reset", {peak_irq_o, valley_irq_o}, 0);
        check_eq("R1", "active in reset", active_o, 0);
        rst_n = 1'b1;
        check_eq("R1", "cnt after release", cnt_o, 0);
    endtask

    // R2..R5: run the counter and compare irqs with a spec model of the cull rule.
    task automatic t_cull(int p, int n, bit pie, bit vie, int cycles, string req);
        int left = 0;
        int cnt_bad = 0;
        int irq_bad = 0;
        int fires = 0;
        logic [CNT_W-1:0] pc;
        logic pu;
        bit pe, ve, hit, f;
        period_i    = CNT_W'(p);
        cull_n_i    = CULL_W'(n);
        peak_ie_i   = pie;
        valley_ie_i = vie;
        imm_mode_i  = 1'b1;
        do_reset();
        pc = cnt_o;
        pu = cnt_up_o;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            pe  = pu && (int'(pc) == p);
            ve  = !pu && (pc == 0);
            hit = (pe && pie) || (ve && vie);
            f   = hit && (left == 0);
            if (hit) left = f ? n : left - 1;
            if (pe) begin
                if (!(cnt_o == CNT_W'(p - 1) && !cnt_up_o)) cnt_bad++;
            end else if (ve) begin
                if (!(cnt_o == 1 && cnt_up_o)) cnt_bad++;
            end else if (pu) begin
                if (!(cnt_o == pc + 1'b1 && cnt_up_o)) cnt_bad++;
            end else begin
                if (!(cnt_o == pc - 1'b1 && !cnt_up_o)) cnt_bad++;
            end
            if (peak_irq_o != (pe && pie && f)) irq_bad++;
            if (valley_irq_o != (ve && vie && f)) irq_bad++;
            if (peak_irq_o || valley_irq_o) fires++;
            pc = cnt_o;
            pu = cnt_up_o;
        end
        check_eq("R2", $sformatf("counter steps p=%0d", p), cnt_bad, 0);
        check_eq(req, $sformatf("irq pattern n=%0d pie=%0d vie=%0d", n, pie, vie), irq_bad, 0);
        check_eq(req, "irq seen iff a source is enabled", fires > 0, pie || vie);
    endtask

    // R2: zero period parks the counter.
    task automatic t_zero_period();
        period_i  = '0;
        peak_ie_i = 1'b1;
        valley_ie_i = 1'b1;
        cull_n_i  = '0;
        do_reset();
        repeat (10) @(negedge clk);
        check_eq("R2", "zero period count", cnt_o, 0);
        check_eq("R2", "zero period no irq", {peak_irq_o, valley_irq_o}, 0);
    endtask

    // R6: immediate mode.
    task automatic t_immediate();
        period_i   = 8'd4;
        imm_mode_i = 1'b1;
        cull_n_i   = '0;
        do_reset();
        do_write(2, 16'hBEEF);
        check_eq("R6", "slot2 immediate", slot(2), 16'hBEEF);
        do_write(0, 16'h0A0A);
        check_eq("R6", "slot0 immediate", slot(0), 16'h0A0A);
    endtask

    // R7 + R9: batch mode, transfer at every event once armed.
    task automatic t_batch_every();
        logic [CNT_W-1:0] pc;
        logic pu;
        bit seen = 0;
        period_i    = 8'd4;
        imm_mode_i  = 1'b0;
        xfer_cull_i = 1'b0;
        cull_n_i    = '0;
        peak_ie_i   = 1'b0;
        valley_ie_i = 1'b0;
        do_reset();
        do_write(0, 16'h1111);
        repeat (12) @(negedge clk);
        check_eq("R7", "unarmed slot0 held", slot(0), 0);
        pc = cnt_o;
        pu = cnt_up_o;
        do_write(1, 16'h2222);
        for (int c = 0; c < 20 && !seen; c++) begin
            if (slot(1) != 0) begin
                seen = 1;
                check_eq("R7", "transfer follows an event sample",
                         (pu && pc == 4) || (!pu && pc == 0), 1);
            end else begin
                pc = cnt_o;
                pu = cnt_up_o;
                @(negedge clk);
            end
        end
        check_eq("R7", "slot1 loaded", slot(1), 16'h2222);
        check_eq("R7", "slot0 loaded with slot1", slot(0), 16'h1111);
        do_write(3, 16'h5555);
        repeat (20) @(negedge clk);
        check_eq("R9", "disarmed slot3 held", slot(3), 0);
    endtask

    // R8 + R4: transfers only at interrupt events.
    task automatic t_batch_culled(bit xc, int n);
        int peaks = 0;
        bit seen = 0;
        period_i    = 8'd4;
        imm_mode_i  = 1'b0;
        xfer_cull_i = xc;
        cull_n_i    = CULL_W'(n);
        peak_ie_i   = 1'b1;
        valley_ie_i = 1'b0;
        do_reset();
        do_write(1, 16'h3333);
        for (int c = 0; c < 40 && !seen; c++) begin
            if (slot(1) == 16'h3333) seen = 1;
            else @(negedge clk);
        end
        check_eq("R8", $sformatf("first load xc=%0d", xc), slot(1), 16'h3333);
        check_eq("R8", "first load with peak irq", peak_irq_o, 1);
        do_write(1, 16'h4444);
        seen = 0;
        for (int c = 0; c < 200 && !seen; c++) begin
            if (slot(1) == 16'h4444) begin
                seen = 1;
            end else begin
                if (cnt_up_o && cnt_o == 4) peaks++;
                @(negedge clk);
            end
        end
        check_eq("R8", "second load with peak irq", peak_irq_o, 1);
        check_eq("R4", $sformatf("peaks until culled load n=%0d", n), peaks, n + 1);
    endtask

    // R10: arming write coinciding with a transfer.
    task automatic t_coincide();
        int c = 0;
        period_i    = 8'd4;
        imm_mode_i  = 1'b0;
        xfer_cull_i = 1'b0;
        cull_n_i    = '0;
        do_reset();
        do_write(1, 16'hAAAA);
        while (!(cnt_up_o && cnt_o == 4) && c < 20) begin
            @(negedge clk);
            c++;
        end
        do_write(1, 16'hBBBB);
        check_eq("R10", "old value copied", slot(1), 16'hAAAA);
        c = 0;
        while (!(!cnt_up_o && cnt_o == 0) && c < 20) begin
            @(negedge clk);
            c++;
        end
        @(negedge clk);
        check_eq("R10", "still armed, new value loads", slot(1), 16'hBBBB);
    endtask

    initial begin
        t_reset();
        t_cull(3, 0, 1, 1, 60, "R4");
        t_cull(3, 3, 1, 1, 150, "R4");
        t_cull(1, 2, 1, 1, 80, "R4");
        t_cull(3, 31, 1, 0, 420, "R4");
        t_cull(5, 2, 0, 1, 150, "R5");
        t_cull(4, 0, 0, 0, 40, "R5");
        t_cull(4, 1, 1, 1, 100, "R3");
        t_zero_period();
        t_immediate();
        t_batch_every();
        t_batch_culled(1'b1, 2);
        t_batch_culled(1'b0, 1);
        t_coincide();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule